// File: doc/BRIEF.md
# Compare-Branch Fusing Decode Slotter

This block sits between instruction pre-decode and the decoders of a wide front end. Each cycle it looks at a window of up to four pre-decoded instruction records, held in program order, and hands them out to four decode slots. Slot 0 is the complex decoder. Slots 1 to 3 are simple decoders that each emit exactly one micro-op. The block then reports how many window entries it used up, so the front end knows how far to advance the window.

When a flag-writing compare or test is directly followed by a conditional branch, the block merges the two into one fused micro-op. Only the complex slot can fuse. So the slotter cuts the window before any pair that does not start at position 0, and such a pair gets at most one fusion per cycle. An instruction that needs several micro-ops is also kept to slot 0. A fusible compare that is the last entry of the window is held back once, which gives its branch a chance to arrive. All outputs are registered one cycle after the window is presented.

Top module: `dslot_fuse_decode`

## Requirements
- R1: The valid bits of the window are contiguous from position 0. Slot 0 takes the first entry, and slots 1 to 3 take the following entries in program order. `out_consumed` equals the number of window entries used this cycle. A window with `in_vld[0]`=0 consumes nothing and fills no slot.
- R2: An entry at position 0 fuses with the entry at position 1 when both of the following hold:
  - Position 0 has class 2'b01 (compare/test), its flag-writing bit set, its branch bit clear and one micro-op.
  - Position 1 is valid, has its branch bit set and has one micro-op.
  The fused pair fills slot 0 with `out_fused[0]`=1 and one micro-op, and consumes two entries.
- R3: Fusion happens only in slot 0, so `out_fused[3:1]` is always 0. An eligible pair starting at position k>0 cuts the window, and `out_consumed`=k.
- R4: At most one pair fuses per cycle. In a window of compare, branch, compare, branch, only the first pair is taken, and `out_consumed`=2.
- R5: A load (class 2'b10), or a compare whose flag-writing bit is clear, never fuses. A load, compare, branch sequence consumes only the load in that cycle. The compare and branch then fuse when they reach position 0.
- R6: An entry needing more than one micro-op issues only from slot 0. At any later position it cuts the window. Slot 0 emits min(n, 4) micro-ops for a count n.
- R7: `out_uop_total` is the sum of the micro-ops of the filled slots and never exceeds 7. Each filled simple slot carries exactly one micro-op.
- R8: A fusible compare that is the last valid entry and sits at position k>0 cuts the window (`out_consumed`=k). Held back like this, or found alone at position 0, it waits at most one cycle. A lone compare at position 0 consumes 0 once, then issues unfused on the next cycle. A fusible compare followed by a valid non-branch issues normally.
- R9: Outputs change only on the clock edge after the window is presented. Reset clears all outputs and the hold state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 4 | Valid bit per window position |
| in_cls | input | 8 | 2-bit class per position (00 ALU, 01 compare/test, 10 load, 11 other) |
| in_flg | input | 4 | Flag-writing bit per position |
| in_brc | input | 4 | Conditional-branch bit per position |
| in_uops | input | 12 | 3-bit micro-op count per position |
| out_vld | output | 4 | Slot filled, slot 0 is the complex decoder |
| out_cls | output | 8 | Class per slot |
| out_uops | output | 12 | Micro-ops emitted per slot |
| out_fused | output | 4 | Fused marker per slot |
| out_consumed | output | 3 | Window entries consumed |
| out_uop_total | output | 3 | Total micro-ops emitted this cycle |

## Verification
Three behaviours can meet in one window: fusion at slot 0, a second eligible pair further along, and a multi-micro-op or held-back compare that must cut the window. The bench builds windows that mix them. Examples are compare-branch-compare-branch, load ahead of a pair, a mid-window multi-micro-op entry, and a compare arriving last. The bench judges each case by the slot contents, the fused marker and the consumed count it works out by hand. The one-cycle hold is followed across consecutive cycles to show that a compare is never stalled twice.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  localparam int CLS_W = 2;
  localparam int UOP_W = 3;
  localparam logic [CLS_W-1:0] CLS_ALU  = 2'b00;
  localparam logic [CLS_W-1:0] CLS_CMP  = 2'b01;
  localparam logic [CLS_W-1:0] CLS_LOAD = 2'b10;

  // A record may head a fused pair: flag-writing single-uop compare/test.
  function automatic logic fuse_head(logic v, logic [CLS_W-1:0] c, logic f,
                                     logic b, logic [UOP_W-1:0] n);
    return v && (c == CLS_CMP) && f && !b && (n == UOP_W'(1));
  endfunction

  // A record may close a fused pair: single-uop conditional branch.
  function automatic logic fuse_tail(logic v, logic b, logic [UOP_W-1:0] n);
    return v && b && (n == UOP_W'(1));
  endfunction

  // Micro-ops the complex slot emits for a count n.
  function automatic logic [UOP_W-1:0] cplx_uops(logic [UOP_W-1:0] n, int lim);
    return (int'(n) > lim) ? UOP_W'(lim) : n;
  endfunction
endpackage

// File: rtl/dslot_pair_scan.sv
module dslot_pair_scan
  import dslot_pkg::*;
#(
  parameter int N_POS = 4
) (
  input  logic [N_POS-1:0]       vld,
  input  logic [N_POS*CLS_W-1:0] cls,
  input  logic [N_POS-1:0]       flg,
  input  logic [N_POS-1:0]       brc,
  input  logic [N_POS*UOP_W-1:0] uops,
  output logic [N_POS-1:0]       pair_ok,
  output logic [N_POS-1:0]       tail_ok
);
  logic [N_POS-1:0] head;

  for (genvar k = 0; k < N_POS; k++) begin : g_pos
    assign head[k] = fuse_head(vld[k], cls[k*CLS_W +: CLS_W], flg[k], brc[k],
                               uops[k*UOP_W +: UOP_W]);
    if (k < N_POS - 1) begin : g_mid
      assign pair_ok[k] = head[k] &&
                          fuse_tail(vld[k+1], brc[k+1], uops[(k+1)*UOP_W +: UOP_W]);
      assign tail_ok[k] = head[k] && !vld[k+1];
    end else begin : g_last
      assign pair_ok[k] = 1'b0;
      assign tail_ok[k] = head[k];
    end
  end
endmodule

// File: rtl/dslot_steer.sv
module dslot_steer
  import dslot_pkg::*;
#(
  parameter int N_POS     = 4,
  parameter int CPLX_UOPS = 4,
  localparam int CNT_W    = $clog2(N_POS + 1)
) (
  input  logic [N_POS-1:0]       vld,
  input  logic [N_POS*CLS_W-1:0] cls,
  input  logic [N_POS*UOP_W-1:0] uops,
  input  logic [N_POS-1:0]       pair_ok,
  input  logic [N_POS-1:0]       tail_ok,
  input  logic                   held,
  output logic [N_POS-1:0]       s_vld,
  output logic [N_POS*CLS_W-1:0] s_cls,
  output logic [N_POS*UOP_W-1:0] s_uops,
  output logic [N_POS-1:0]       s_fused,
  output logic [CNT_W-1:0]       take,
  output logic                   hold0,
  output logic                   tail_cut
);
  always_comb begin
    int  nxt;
    int  slot;
    int  taken;
    logic stop;
    s_vld    = '0;
    s_cls    = '0;
    s_uops   = '0;
    s_fused  = '0;
    hold0    = 1'b0;
    tail_cut = 1'b0;
    stop     = 1'b0;
    nxt      = 0;
    slot     = 1;
    taken    = 0;
    // complex slot: fusion, lone-compare hold, or any single entry
    if (!vld[0]) begin
      stop = 1'b1;
    end else if (pair_ok[0]) begin
      s_vld[0]         = 1'b1;
      s_fused[0]       = 1'b1;
      s_cls[0 +: CLS_W] = cls[0 +: CLS_W];
      s_uops[0 +: UOP_W] = UOP_W'(1);
      taken = 2;
      nxt   = 2;
    end else if (tail_ok[0] && !held) begin
      hold0 = 1'b1;
      stop  = 1'b1;
    end else begin
      s_vld[0]           = 1'b1;
      s_cls[0 +: CLS_W]  = cls[0 +: CLS_W];
      s_uops[0 +: UOP_W] = cplx_uops(uops[0 +: UOP_W], CPLX_UOPS);
      taken = 1;
      nxt   = 1;
    end
    // simple slots: single-uop entries in order until a cut point
    for (int p = 1; p < N_POS; p++) begin
      if (!stop && p >= nxt) begin
        if (!vld[p] || uops[p*UOP_W +: UOP_W] != UOP_W'(1)) begin
          stop = 1'b1;
        end else if (pair_ok[p] || tail_ok[p]) begin
          stop     = 1'b1;
          tail_cut = tail_ok[p];
        end else begin
          s_vld[slot]                = 1'b1;
          s_cls[slot*CLS_W +: CLS_W] = cls[p*CLS_W +: CLS_W];
          s_uops[slot*UOP_W +: UOP_W] = UOP_W'(1);
          slot  = slot + 1;
          taken = taken + 1;
        end
      end
    end
    take = CNT_W'(taken);
  end
endmodule

// File: rtl/dslot_fuse_decode.sv
module dslot_fuse_decode
  import dslot_pkg::*;
#(
  parameter int N_POS     = 4,
  parameter int CPLX_UOPS = 4,
  localparam int CNT_W    = $clog2(N_POS + 1),
  localparam int TOT_W    = $clog2(CPLX_UOPS + N_POS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_POS-1:0]       in_vld,
  input  logic [N_POS*CLS_W-1:0] in_cls,
  input  logic [N_POS-1:0]       in_flg,
  input  logic [N_POS-1:0]       in_brc,
  input  logic [N_POS*UOP_W-1:0] in_uops,
  output logic [N_POS-1:0]       out_vld,
  output logic [N_POS*CLS_W-1:0] out_cls,
  output logic [N_POS*UOP_W-1:0] out_uops,
  output logic [N_POS-1:0]       out_fused,
  output logic [CNT_W-1:0]       out_consumed,
  output logic [TOT_W-1:0]       out_uop_total
);
  logic [N_POS-1:0]       pair_ok, tail_ok, s_vld, s_fused;
  logic [N_POS*CLS_W-1:0] s_cls;
  logic [N_POS*UOP_W-1:0] s_uops;
  logic [CNT_W-1:0]       take;
  logic                   hold0, tail_cut, held_q;
  logic [TOT_W-1:0]       tot_d;
  logic                   stall_evt, stall_q;

  dslot_pair_scan #(.N_POS(N_POS)) u_scan (
    .vld(in_vld), .cls(in_cls), .flg(in_flg), .brc(in_brc), .uops(in_uops),
    .pair_ok(pair_ok), .tail_ok(tail_ok)
  );

  dslot_steer #(.N_POS(N_POS), .CPLX_UOPS(CPLX_UOPS)) u_steer (
    .vld(in_vld), .cls(in_cls), .uops(in_uops), .pair_ok(pair_ok),
    .tail_ok(tail_ok), .held(held_q), .s_vld(s_vld), .s_cls(s_cls),
    .s_uops(s_uops), .s_fused(s_fused), .take(take), .hold0(hold0),
    .tail_cut(tail_cut)
  );

  always_comb begin
    int acc;
    acc = 0;
    for (int k = 0; k < N_POS; k++) acc = acc + int'(s_uops[k*UOP_W +: UOP_W]);
    tot_d = TOT_W'(acc);
  end

  // a valid window that moved nothing forward
  assign stall_evt = in_vld[0] && (take == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld       <= '0;
      out_cls       <= '0;
      out_uops      <= '0;
      out_fused     <= '0;
      out_consumed  <= '0;
      out_uop_total <= '0;
      held_q        <= 1'b0;
      stall_q       <= 1'b0;
    end else begin
      out_vld       <= s_vld;
      out_cls       <= s_cls;
      out_uops      <= s_uops;
      out_fused     <= s_fused;
      out_consumed  <= take;
      out_uop_total <= tot_d;
      held_q        <= hold0 | tail_cut;
      stall_q       <= stall_evt;
    end
  end

  // R1: every consumed entry shows up in a slot (a fused slot covers two)
  a_r1_consume_match: assert property (@(posedge clk) disable iff (!rst_n)
    int'(out_consumed) == $countones(out_vld) + $countones(out_fused));
  // R3: fusion only in the complex slot
  a_r3_fuse_complex: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fused >> 1) == '0);
  // R4: one fusion per cycle
  a_r4_one_fusion: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_fused));
  // R8: a compare is never held two cycles in a row
  a_r8_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q |=> !stall_q);
  // R8: a hold only happens when the previous cycle did not already hold
  a_r8_hold_gap: assert property (@(posedge clk) disable iff (!rst_n)
    hold0 |-> !held_q);

  for (genvar k = 1; k < N_POS; k++) begin : g_simple_chk
    // R6, R7: simple slots carry exactly one micro-op
    a_r6_simple_uop: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[k] |-> out_uops[k*UOP_W +: UOP_W] == UOP_W'(1));
  end
endmodule

// File: tb/dslot_fuse_decode_test.sv
`timescale 1ns/100ps
module dslot_fuse_decode_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  in_vld, in_flg, in_brc;
  logic [7:0]  in_cls;
  logic [11:0] in_uops;
  logic [3:0]  out_vld, out_fused;
  logic [7:0]  out_cls;
  logic [11:0] out_uops;
  logic [2:0]  out_consumed, out_uop_total;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dslot_fuse_decode uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_cls(in_cls),
    .in_flg(in_flg), .in_brc(in_brc), .in_uops(in_uops),
    .out_vld(out_vld), .out_cls(out_cls), .out_uops(out_uops),
    .out_fused(out_fused), .out_consumed(out_consumed),
    .out_uop_total(out_uop_total)
  );

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic clr();
    in_vld = '0; in_cls = '0; in_flg = '0; in_brc = '0; in_uops = '0;
  endtask

  task automatic put(int p, logic [1:0] c, logic f, logic b, logic [2:0] n);
    in_vld[p] = 1'b1; in_cls[p*2 +: 2] = c; in_flg[p] = f;
    in_brc[p] = b; in_uops[p*3 +: 3] = n;
  endtask

  task automatic alu(int p);  put(p, 2'b00, 1'b1, 1'b0, 3'd1); endtask
  task automatic cmp(int p);  put(p, 2'b01, 1'b1, 1'b0, 3'd1); endtask
  task automatic br(int p);   put(p, 2'b11, 1'b0, 1'b1, 3'd1); endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic expect_out(string req, int cons, int vld, int fus, int tot);
    chk(req, "consumed", int'(out_consumed), cons);
    chk(req, "slot valid", int'(out_vld), vld);
    chk(req, "fused", int'(out_fused), fus);
    chk(req, "uop total", int'(out_uop_total), tot);
  endtask

  task automatic t_reset();
    expect_out("R9", 0, 0, 0, 0);
    chk("R9", "slot uops", int'(out_uops), 0);
  endtask

  task automatic t_plain();
    clr(); alu(0); alu(1); alu(2); alu(3);
    #1 chk("R9", "consumed before edge", int'(out_consumed), 0);
    step(); expect_out("R1", 4, 4'b1111, 0, 4);
    clr(); alu(0); alu(1);
    step(); expect_out("R1", 2, 4'b0011, 0, 2);
    clr();
    step(); expect_out("R1", 0, 0, 0, 0);
  endtask

  task automatic t_fuse_front();
    clr(); cmp(0); br(1); alu(2); alu(3);
    step(); expect_out("R2", 4, 4'b0111, 4'b0001, 3);
    chk("R2", "slot0 class", int'(out_cls[1:0]), 1);
    chk("R2", "slot0 uops", int'(out_uops[2:0]), 1);
  endtask

  task automatic t_fuse_mid();
    clr(); alu(0); cmp(1); br(2); alu(3);
    step(); expect_out("R3", 1, 4'b0001, 0, 1);
  endtask

  task automatic t_two_pairs();
    clr(); cmp(0); br(1); cmp(2); br(3);
    step(); expect_out("R4", 2, 4'b0001, 4'b0001, 1);
  endtask

  task automatic t_load();
    clr(); put(0, 2'b10, 1'b0, 1'b0, 3'd1); cmp(1); br(2); alu(3);
    step(); expect_out("R5", 1, 4'b0001, 0, 1);
    clr(); cmp(0); br(1); alu(2);
    step(); expect_out("R5", 3, 4'b0011, 4'b0001, 2);
    clr(); put(0, 2'b01, 1'b0, 1'b0, 3'd1); br(1);
    step(); expect_out("R5", 2, 4'b0011, 0, 2);
    clr(); put(0, 2'b10, 1'b1, 1'b0, 3'd1); br(1);
    step(); expect_out("R5", 2, 4'b0011, 0, 2);
  endtask

  task automatic t_multi();
    clr(); alu(0); put(1, 2'b00, 1'b1, 1'b0, 3'd3); alu(2);
    step(); expect_out("R6", 1, 4'b0001, 0, 1);
    clr(); put(0, 2'b00, 1'b1, 1'b0, 3'd5); alu(1); alu(2);
    step(); expect_out("R6", 3, 4'b0111, 0, 6);
    chk("R6", "slot0 clamped uops", int'(out_uops[2:0]), 4);
    clr(); put(0, 2'b11, 1'b0, 1'b0, 3'd4); alu(1); alu(2); alu(3);
    step(); expect_out("R7", 4, 4'b1111, 0, 7);
    chk("R7", "simple slot uops", int'(out_uops[11:3]), 9'b001_001_001);
  endtask

  task automatic t_tail();
    clr(); alu(0); alu(1); cmp(2);
    step(); expect_out("R8", 2, 4'b0011, 0, 2);
    clr(); cmp(0);
    step(); expect_out("R8", 1, 4'b0001, 0, 1);
    clr(); cmp(0);
    step(); expect_out("R8", 0, 0, 0, 0);
    step(); expect_out("R8", 1, 4'b0001, 0, 1);
    clr(); alu(0); cmp(1); alu(2); alu(3);
    step(); expect_out("R8", 4, 4'b1111, 0, 4);
    clr(); alu(0); alu(1); alu(2); cmp(3);
    step(); expect_out("R8", 3, 4'b0111, 0, 3);
    clr(); cmp(0); br(1);
    step(); expect_out("R8", 2, 4'b0001, 4'b0001, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clr();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_fuse_front();
    t_fuse_mid();
    t_two_pairs();
    t_load();
    t_multi();
    t_tail();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule